// File: doc/BRIEF.md
# Host-Side Parallel Port Controller with EPP Handshake

This block is the host end of a printer-style parallel port. It drives the four control lines toward the connector, samples the five status lines, and gives the processor a small register bus. The port data byte never passes through the block. An external octal latch holds outgoing data and an external buffer brings incoming data onto the `pd_in` input. The block produces the latch load or chip-select strobe and the latch output enable.

Three operating modes are selected by a mode register. In compatible mode the control lines act as open-drain strobes that software sets one by one. Bidirectional mode adds a read direction, in which the latch is disabled so the peripheral can drive the data lines. In EPP mode, accesses to the EPP address or EPP data register run a hardware handshake on the control lines. The handshake is stretched for as long as the peripheral holds WAIT. It is aborted, and a sticky timeout flag is set, if WAIT never clears.

Each control line is described by a value and a drive-enable. "Released" means the drive-enable is 0. "Driven low" means the enable is 1 and the value is 0.

Top module: `epp_port_ctrl`

## Requirements

### Register bus and reset
- R1: After reset, the following hold:
  - the mode is compatible (0);
  - every control line is released (`ctl_en` = 0);
  - `bus_ready`, `bus_irq` and `latch_we` are 0;
  - `latch_oe_n` is 0.
- R2: A request to the data (address 0), status (1), control (2) or mode (5) register ends with `bus_ready` high for one cycle, in the cycle after the request edge.
  - Read data is valid in that same cycle.
  - The control register reads back its six bits. The mode register reads back its two bits.
  - Mode encoding: 0 is compatible, 1 is bidirectional, 2 is EPP, and 3 behaves as compatible.
- R11: `bus_irq` is high exactly when control bit 4 (interrupt enable) is set and the synchronized acknowledge/interrupt input is high.

### Compatible mode
- R3: In compatible or bidirectional mode, control bits 0..3 map to `ctl_en[0..3]`.
  - The lines are strobe, autofeed, init and select-in, in that order.
  - A set bit drives its line low. A clear bit releases the line.
  - `ctl_o` is always 0 in these modes.
- R4: In compatible mode, a write to the data register pulses `latch_we` for exactly one cycle, in the ready cycle.
  - Reads do not pulse `latch_we`.
  - `latch_oe_n` stays 0 whatever control bit 5 holds.

### Bidirectional mode
- R5: In bidirectional mode:
  - `latch_oe_n` follows control bit 5 (direction).
  - `latch_we` acts as a data-register chip select. It is high in the ready cycle of every data-register read or write.
  - A data-register read returns `pd_in` when bit 5 is set, and the stored byte when bit 5 is clear.

### EPP mode
- R6: In EPP mode, all four control lines are actively driven (`ctl_en` = 4'hF). The line roles are:
  - `ctl_o[0]` is active-low WRITE;
  - `ctl_o[1]` is active-low data strobe;
  - `ctl_o[2]` is the inverse of control bit 2;
  - `ctl_o[3]` is active-low address strobe.
  
  When no cycle is running, WRITE and both strobes are high and `latch_oe_n` is 1.
- R7: An EPP write runs in this order:
  - a setup cycle, in which WRITE goes low and `latch_we` pulses;
  - at least one strobe cycle, on the address strobe for register 3 and on the data strobe for register 4;
  - a ready cycle, in which the strobe is high and WRITE is still low.
  
  WRITE rises after the ready cycle. `latch_oe_n` is 0 from setup through ready.
- R8: An EPP read keeps WRITE high and `latch_oe_n` high. It returns the value of `pd_in` sampled at the edge that ends the strobe.
- R9: The strobe stays low for as long as the synchronized WAIT (busy input) is high. It is released at the first edge on which WAIT is seen low.
- R10: If WAIT stays high for the whole timeout window, the cycle is aborted after exactly TIMEOUT_CYC strobe cycles.
  - A read returns 8'hFF.
  - Status bit 0 is set and stays set until a status-register write with bit 0 at 1.

### Status register
- R12: A status read returns the synchronized inputs in this layout:
  - bit 7 is busy;
  - bit 6 is acknowledge;
  - bit 5 is paper-out;
  - bit 4 is select;
  - bit 3 is error;
  - bits 2..1 are 0;
  - bit 0 is the timeout flag.
  
  The input bus `sts_i` is ordered with error in bit 0, select in bit 1, paper-out in bit 2, acknowledge in bit 3 and busy in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | One-cycle register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle end-of-access pulse |
| bus_irq | output | 1 | Gated peripheral interrupt |
| pd_in | input | 8 | Port data seen through the external input buffer |
| sts_i | input | 5 | Status lines: error, select, paper-out, ack, busy |
| ctl_o | output | 4 | Control line values: strobe/WRITE, autofeed/data strobe, init, select-in/address strobe |
| ctl_en | output | 4 | Drive-enable per control line |
| latch_we | output | 1 | Latch load strobe or data chip select |
| latch_oe_n | output | 1 | Active-low output enable of the external latch |

## Verification
The bench builds the block with TIMEOUT_CYC set to 20 and SYNC_STAGES left at 2. This makes the abort path reachable within a few tens of cycles, so the exact strobe width of an aborted cycle can be counted and compared against the parameter. The two-stage synchronizer sets how many edges a WAIT change needs before it reaches the handshake. The bench therefore holds WAIT high across several sampled strobe cycles before releasing it, which exercises the stretching logic.

// File: rtl/epp_port_pkg.sv
package epp_port_pkg;

  localparam int DATA_W = 8;
  localparam int STS_W  = 5;
  localparam int CTL_W  = 4;

  typedef enum logic [1:0] {
    MODE_COMPAT = 2'b00,
    MODE_BIDIR  = 2'b01,
    MODE_EPP    = 2'b10,
    MODE_RSVD   = 2'b11
  } port_mode_e;

  typedef enum logic [1:0] {
    HS_IDLE   = 2'b00,
    HS_SETUP  = 2'b01,
    HS_STROBE = 2'b10,
    HS_DONE   = 2'b11
  } hs_state_e;

  // register indices
  localparam logic [2:0] RA_DATA  = 3'd0;
  localparam logic [2:0] RA_STAT  = 3'd1;
  localparam logic [2:0] RA_CTRL  = 3'd2;
  localparam logic [2:0] RA_EADDR = 3'd3;
  localparam logic [2:0] RA_EDATA = 3'd4;
  localparam logic [2:0] RA_MODE  = 3'd5;

  // control register bit positions
  localparam int CB_INIT = 2;
  localparam int CB_IEN  = 4;
  localparam int CB_DIR  = 5;

  // status input positions
  localparam int SI_ACK  = 3;
  localparam int SI_BUSY = 4;

  function automatic port_mode_e decode_mode(logic [1:0] raw);
    port_mode_e m;
    case (raw)
      2'b01:   m = MODE_BIDIR;
      2'b10:   m = MODE_EPP;
      default: m = MODE_COMPAT;
    endcase
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(logic [STS_W-1:0] lvl, logic tmo);
    return {lvl, 2'b00, tmo};
  endfunction

  function automatic logic is_epp_reg(logic [2:0] a);
    return (a == RA_EADDR) || (a == RA_EDATA);
  endfunction

endpackage

// File: rtl/epp_in_sync.sv
module epp_in_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/epp_regfile.sv
module epp_regfile
  import epp_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ext_data,
  input  logic [STS_W-1:0]  sts_lvl,
  input  logic              tmo_set,
  output port_mode_e        mode_o,
  output logic [5:0]        ctrl_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              latch_pulse_o
);

  logic [DATA_W-1:0] data_q;
  logic [5:0]        ctrl_q;
  logic [1:0]        mode_q;
  logic              tmo_q;
  logic              ready_q;
  logic              lp_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  port_mode_e        mode_cur;
  logic              data_hit;
  logic              tmo_clear;

  assign mode_cur  = decode_mode(mode_q);
  assign data_hit  = req && (addr == RA_DATA);
  assign tmo_clear = req && we && (addr == RA_STAT) && wdata[0];

  always_comb begin
    case (addr)
      RA_DATA: rd_mux = (mode_cur == MODE_BIDIR && ctrl_q[CB_DIR]) ? ext_data : data_q;
      RA_STAT: rd_mux = pack_status(sts_lvl, tmo_q);
      RA_CTRL: rd_mux = {2'b00, ctrl_q};
      RA_MODE: rd_mux = {6'b0, mode_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      ctrl_q  <= '0;
      mode_q  <= 2'b00;
      tmo_q   <= 1'b0;
      ready_q <= 1'b0;
      lp_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= req;
      lp_q    <= data_hit && (we || mode_cur == MODE_BIDIR);
      if (req) rdata_q <= rd_mux;
      if (tmo_set)        tmo_q <= 1'b1;
      else if (tmo_clear) tmo_q <= 1'b0;
      if (req && we) begin
        case (addr)
          RA_DATA: data_q <= wdata;
          RA_CTRL: ctrl_q <= wdata[5:0];
          RA_MODE: mode_q <= wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  assign mode_o        = mode_cur;
  assign ctrl_o        = ctrl_q;
  assign ready_o       = ready_q;
  assign rdata_o       = rdata_q;
  assign latch_pulse_o = lp_q;

  // R10
  tmo_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> $past(tmo_set));

endmodule

// File: rtl/epp_handshake.sv
module epp_handshake
  import epp_port_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              we,
  input  logic              is_addr,
  input  logic              wait_lvl,
  input  logic [DATA_W-1:0] ext_data,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              abort_o,
  output logic              wr_act_o,
  output logic              dstrb_o,
  output logic              astrb_o,
  output logic              latch_load_o
);

  localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYC - 1);

  hs_state_e         state;
  logic              wr_q;
  logic              addr_q;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] rdata_q;
  logic              strb_act;
  logic              abort_now;

  assign strb_act  = (state == HS_STROBE);
  assign abort_now = strb_act && wait_lvl && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= HS_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= 1'b0;
      cnt     <= '0;
      rdata_q <= '0;
    end else begin
      case (state)
        HS_IDLE: if (start) begin
          state  <= HS_SETUP;
          wr_q   <= we;
          addr_q <= is_addr;
        end
        HS_SETUP: begin
          state <= HS_STROBE;
          cnt   <= '0;
        end
        HS_STROBE: begin
          if (!wait_lvl) begin
            state   <= HS_DONE;
            rdata_q <= ext_data;
          end else if (abort_now) begin
            state   <= HS_DONE;
            rdata_q <= '1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= HS_IDLE;
          wr_q  <= 1'b0;
        end
      endcase
    end
  end

  assign busy_o       = (state != HS_IDLE);
  assign done_o       = (state == HS_DONE);
  assign rdata_o      = rdata_q;
  assign abort_o      = abort_now;
  assign wr_act_o     = wr_q && (state != HS_IDLE);
  assign dstrb_o      = strb_act && !addr_q;
  assign astrb_o      = strb_act && addr_q;
  assign latch_load_o = (state == HS_SETUP) && wr_q;

  // R9
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_act && wait_lvl && !abort_now) |=> strb_act);

  // R9
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(strb_act) && !$past(abort_now)) |-> !$past(wait_lvl));

  // R10
  timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb_act |-> (cnt <= CNT_LAST));

  // R7
  write_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_act && wr_q) |=> wr_act_o);

endmodule

// File: rtl/epp_pin_drive.sv
module epp_pin_drive
  import epp_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  port_mode_e       mode,
  input  logic [CTL_W-1:0] od_req,
  input  logic             init_bit,
  input  logic             dir_bit,
  input  logic             wr_act,
  input  logic             dstrb,
  input  logic             astrb,
  input  logic             spp_pulse,
  input  logic             epp_load,
  output logic [CTL_W-1:0] ctl_o,
  output logic [CTL_W-1:0] ctl_en,
  output logic             latch_we,
  output logic             latch_oe_n
);

  logic [CTL_W-1:0] od_en;
  logic [CTL_W-1:0] od_val;
  logic [CTL_W-1:0] pp_val;
  logic             epp_mode;

  assign epp_mode = (mode == MODE_EPP);

  for (genvar i = 0; i < CTL_W; i++) begin : g_od
    assign od_en[i]  = od_req[i];
    assign od_val[i] = 1'b0;
  end

  assign pp_val = {~astrb, ~init_bit, ~dstrb, ~wr_act};

  always_comb begin
    if (epp_mode) begin
      ctl_en     = '1;
      ctl_o      = pp_val;
      latch_oe_n = ~wr_act;
    end else begin
      ctl_en     = od_en;
      ctl_o      = od_val;
      latch_oe_n = (mode == MODE_BIDIR) ? dir_bit : 1'b0;
    end
  end

  assign latch_we = spp_pulse | epp_load;

  // R3
  open_drain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !epp_mode |-> ((ctl_o & ctl_en) == '0));

endmodule

// File: rtl/epp_port_ctrl.sv
module epp_port_ctrl
  import epp_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_req,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_ready,
  output logic       bus_irq,
  input  logic [7:0] pd_in,
  input  logic [4:0] sts_i,
  output logic [3:0] ctl_o,
  output logic [3:0] ctl_en,
  output logic       latch_we,
  output logic       latch_oe_n
);

  logic [STS_W-1:0]  sts_s;
  port_mode_e        mode;
  logic [5:0]        ctrl;
  logic              epp_sel;
  logic              spp_req;
  logic              hs_start;
  logic              hs_busy;
  logic              hs_done;
  logic              hs_abort;
  logic              hs_wr;
  logic              hs_dstrb;
  logic              hs_astrb;
  logic              hs_load;
  logic [DATA_W-1:0] hs_rdata;
  logic              rf_ready;
  logic [DATA_W-1:0] rf_rdata;
  logic              rf_pulse;

  epp_in_sync #(.W(STS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sts_i), .q(sts_s)
  );

  assign epp_sel  = (mode == MODE_EPP) && is_epp_reg(bus_addr);
  assign spp_req  = bus_req && !epp_sel && !hs_busy;
  assign hs_start = bus_req && epp_sel && !hs_busy;

  epp_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .req(spp_req), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .ext_data(pd_in), .sts_lvl(sts_s), .tmo_set(hs_abort),
    .mode_o(mode), .ctrl_o(ctrl), .ready_o(rf_ready), .rdata_o(rf_rdata),
    .latch_pulse_o(rf_pulse)
  );

  epp_handshake #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_hs (
    .clk(clk), .rst_n(rst_n), .start(hs_start), .we(bus_we),
    .is_addr(bus_addr == RA_EADDR), .wait_lvl(sts_s[SI_BUSY]), .ext_data(pd_in),
    .busy_o(hs_busy), .done_o(hs_done), .rdata_o(hs_rdata), .abort_o(hs_abort),
    .wr_act_o(hs_wr), .dstrb_o(hs_dstrb), .astrb_o(hs_astrb), .latch_load_o(hs_load)
  );

  epp_pin_drive u_pins (
    .clk(clk), .rst_n(rst_n), .mode(mode), .od_req(ctrl[3:0]),
    .init_bit(ctrl[CB_INIT]), .dir_bit(ctrl[CB_DIR]), .wr_act(hs_wr),
    .dstrb(hs_dstrb), .astrb(hs_astrb), .spp_pulse(rf_pulse), .epp_load(hs_load),
    .ctl_o(ctl_o), .ctl_en(ctl_en), .latch_we(latch_we), .latch_oe_n(latch_oe_n)
  );

  assign bus_ready = rf_ready | hs_done;
  assign bus_rdata = hs_done ? hs_rdata : rf_rdata;
  assign bus_irq   = ctrl[CB_IEN] & sts_s[SI_ACK];

  // R2
  single_source_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_ready && hs_done));

endmodule

// File: tb/epp_port_ctrl_test.sv
module epp_port_ctrl_test;

  localparam int TMO = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_req = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_ready;
  logic       bus_irq;
  logic [7:0] pd_in = '0;
  logic [4:0] sts_i = '0;
  logic [3:0] ctl_o;
  logic [3:0] ctl_en;
  logic       latch_we;
  logic       latch_oe_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  epp_port_ctrl #(.SYNC_STAGES(2), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_irq(bus_irq), .pd_in(pd_in), .sts_i(sts_i),
    .ctl_o(ctl_o), .ctl_en(ctl_en), .latch_we(latch_we), .latch_oe_n(latch_oe_n)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start(logic we, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic bus_finish(output logic [7:0] rd);
    for (int g = 0; g < 200 && !bus_ready; g++) @(negedge clk);
    rd = bus_rdata;
    @(negedge clk);
  endtask

  task automatic reg_wr(logic [2:0] a, logic [7:0] d);
    logic [7:0] dummy;
    bus_start(1'b1, a, d);
    bus_finish(dummy);
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [7:0] d);
    bus_start(1'b0, a, 8'h00);
    bus_finish(d);
  endtask

  task automatic t_reset();
    chk("R1 ctl_en", ctl_en, 4'h0);
    chk("R1 ready", bus_ready, 0);
    chk("R1 irq", bus_irq, 0);
    chk("R1 latch_we", latch_we, 0);
    chk("R1 latch_oe_n", latch_oe_n, 0);
  endtask

  task automatic t_regs();
    logic [7:0] rd;
    bus_start(1'b1, 3'd2, 8'h0A);
    chk("R2 ready timing", bus_ready, 1);
    @(negedge clk);
    chk("R2 ready one cycle", bus_ready, 0);
    reg_rd(3'd2, rd);
    chk("R2 ctrl readback", rd, 8'h0A);
    reg_rd(3'd5, rd);
    chk("R2 mode readback", rd, 8'h00);
  endtask

  task automatic t_compat_pins();
    chk("R3 en", ctl_en, 4'b1010);
    chk("R3 val", ctl_o, 4'b0000);
    reg_wr(3'd2, 8'h25);
    chk("R3 en2", ctl_en, 4'b0101);
    chk("R4 oe ignores dir", latch_oe_n, 0);
  endtask

  task automatic t_compat_latch();
    logic [7:0] rd;
    bus_start(1'b1, 3'd0, 8'h3C);
    chk("R4 pulse", latch_we, 1);
    @(negedge clk);
    chk("R4 pulse end", latch_we, 0);
    bus_start(1'b0, 3'd0, 8'h00);
    chk("R4 no read pulse", latch_we, 0);
    chk("R2 data readback", bus_rdata, 8'h3C);
    @(negedge clk);
  endtask

  task automatic t_bidir();
    logic [7:0] rd;
    reg_wr(3'd5, 8'h01);
    reg_wr(3'd2, 8'h20);
    chk("R5 oe follows dir", latch_oe_n, 1);
    pd_in = 8'h5A;
    bus_start(1'b0, 3'd0, 8'h00);
    chk("R5 cs on read", latch_we, 1);
    chk("R5 read pd_in", bus_rdata, 8'h5A);
    @(negedge clk);
    reg_wr(3'd2, 8'h00);
    chk("R5 oe dir clear", latch_oe_n, 0);
    bus_start(1'b1, 3'd0, 8'h66);
    chk("R5 cs on write", latch_we, 1);
    @(negedge clk);
    reg_rd(3'd0, rd);
    chk("R5 stored byte", rd, 8'h66);
    chk("R3 bidir open drain", ctl_en, 4'h0);
  endtask

  task automatic t_status();
    logic [7:0] rd;
    sts_i = 5'b10101;
    repeat (4) @(negedge clk);
    reg_rd(3'd1, rd);
    chk("R12 status layout", rd, 8'hA8);
    sts_i = 5'b00000;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_irq();
    reg_wr(3'd2, 8'h10);
    sts_i = 5'b01000;
    repeat (4) @(negedge clk);
    chk("R11 irq on", bus_irq, 1);
    reg_wr(3'd2, 8'h00);
    chk("R11 irq gated", bus_irq, 0);
    sts_i = 5'b00000;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_epp_idle();
    reg_wr(3'd5, 8'h02);
    reg_wr(3'd2, 8'h04);
    chk("R6 en", ctl_en, 4'hF);
    chk("R6 idle vals", ctl_o, 4'b1011);
    chk("R6 oe idle", latch_oe_n, 1);
  endtask

  task automatic t_epp_addr_write();
    bus_start(1'b1, 3'd3, 8'h77);
    chk("R7 setup vals", ctl_o, 4'b1010);
    chk("R7 setup load", latch_we, 1);
    chk("R7 setup oe", latch_oe_n, 0);
    @(negedge clk);
    chk("R7 strobe vals", ctl_o, 4'b0010);
    chk("R7 strobe load off", latch_we, 0);
    @(negedge clk);
    chk("R7 ready", bus_ready, 1);
    chk("R7 ready vals", ctl_o, 4'b1010);
    @(negedge clk);
    chk("R7 write released", ctl_o, 4'b1011);
    chk("R7 ready ended", bus_ready, 0);
  endtask

  task automatic t_epp_data_read_wait();
    logic [7:0] rd;
    int low = 0;
    sts_i = 5'b10000;
    repeat (4) @(negedge clk);
    pd_in = 8'hC3;
    bus_start(1'b0, 3'd4, 8'h00);
    chk("R8 read write high", ctl_o[0], 1);
    chk("R8 read oe", latch_oe_n, 1);
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      if (!ctl_o[1]) low++;
      @(negedge clk);
    end
    chk("R9 held while wait", low, 6);
    sts_i = 5'b00000;
    bus_finish(rd);
    chk("R8 read data", rd, 8'hC3);
  endtask

  task automatic t_timeout();
    logic [7:0] rd;
    int low = 0;
    int g = 0;
    sts_i = 5'b10000;
    repeat (4) @(negedge clk);
    bus_start(1'b0, 3'd4, 8'h00);
    while (!bus_ready && g < 200) begin
      if (!ctl_o[1]) low++;
      @(negedge clk);
      g++;
    end
    chk("R10 strobe cycles", low, TMO);
    chk("R10 abort data", bus_rdata, 8'hFF);
    @(negedge clk);
    reg_rd(3'd1, rd);
    chk("R10 flag set", rd[0], 1);
    reg_wr(3'd1, 8'h00);
    reg_rd(3'd1, rd);
    chk("R10 flag sticky", rd[0], 1);
    reg_wr(3'd1, 8'h01);
    reg_rd(3'd1, rd);
    chk("R10 flag cleared", rd[0], 0);
    sts_i = 5'b00000;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_regs();
    t_compat_pins();
    t_compat_latch();
    t_bidir();
    t_status();
    t_irq();
    t_epp_idle();
    t_epp_addr_write();
    t_epp_data_read_wait();
    t_timeout();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule